// File: doc/BRIEF.md
# Loadable Wrapping Counter with Terminal-Count Flag

This block is a synchronous up-counter whose range is set by a modulus parameter. On every rising clock edge it either clears, takes a parallel word, steps by one, or holds. A fixed priority decides between these actions. After the top value of the range, modulus minus one, the next step returns the count to zero.

A combinational terminal-count flag goes high in the cycle before a counting wrap. It depends only on the current count and the count enable, so a higher-order counter can use it as its own count enable. The clear is synchronous. There is no asynchronous reset.

Top module: `wrapCounter`

## Requirements
- R1: When `clr` is 1 at a rising edge, the count becomes zero, whatever `ld` and `cnt` are.
- R2: When `clr` is 0 and `ld` is 1 at a rising edge, the count becomes `loadVal`, whatever `cnt` is.
- R3: When `clr` and `ld` are 0, `cnt` is 1 and the count is below MOD-1, the count rises by one at the edge.
- R4: When `clr` and `ld` are 0, `cnt` is 1 and the count equals MOD-1, the count becomes zero at the edge.
- R5: When `clr`, `ld` and `cnt` are all 0, the count keeps its value across the edge.
- R6: `termCnt` is 1 exactly when the count equals MOD-1 and `cnt` is 1 in the same cycle. Otherwise it is 0. It is valid without waiting for a clock edge.
- R7: If a value of MOD or above has been loaded, the next counting step (`clr`=0, `ld`=0, `cnt`=1) returns the count to zero. `termCnt` stays 0 while the count holds such a value.
- R8: `termCnt` is not masked by `clr` or `ld`. With the count at MOD-1 and `cnt`=1, the flag is 1 even while a clear or load is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear; highest priority |
| ld | input | 1 | Parallel load enable; second priority |
| cnt | input | 1 | Count enable; lowest priority |
| loadVal | input | $clog2(MOD) | Word taken on a load |
| count | output | $clog2(MOD) | Current count |
| termCnt | output | 1 | Terminal count: count is MOD-1 while `cnt` is 1 |

## Verification
The checker tests the next-state rule on every cycle once a first clear has been seen. That rule covers the clear, load, step, wrap and hold cases, the out-of-range wrap, and the link between the flag, the count and `cnt`. A cycle-by-cycle model in the bench compares the count and the flag on every clock. Only the bench's scenarios show certain things. They show that combined controls such as clear with load, or load with count, resolve by priority. They show that loaded values of MOD and above behave as required. They also show that the flag stays up during a pending clear or load. Long counting runs confirm repeated wraps.

// File: rtl/wrapCounterPkg.sv
package wrapCounterPkg;
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doStep;
  } ctrlStrobes_t;
endpackage

// File: rtl/wrapCounterCtrl.sv
module wrapCounterCtrl
  import wrapCounterPkg::*;
(
  input  logic         clr,
  input  logic         ld,
  input  logic         cnt,
  input  logic         atLast,
  output ctrlStrobes_t strobes,
  output logic         termCnt
);
  // Priority: clear beats load, load beats step
  always_comb begin
    strobes = '0;
    if (clr)      strobes.doClear = 1'b1;
    else if (ld)  strobes.doLoad  = 1'b1;
    else if (cnt) strobes.doStep  = 1'b1;
  end

  // Terminal count gated only by the count enable
  assign termCnt = cnt & atLast;
endmodule

// File: rtl/wrapCounterPath.sv
module wrapCounterPath
  import wrapCounterPkg::*;
#(
  parameter int MOD = 10,
  localparam int W = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         atLast
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] countQ;
  logic [W-1:0] stepVal;
  logic         rollOver;

  // Values at or above the top of the range fold back to zero
  assign rollOver = (countQ >= LAST);
  assign stepVal  = rollOver ? '0 : countQ + 1'b1;
  assign atLast   = (countQ == LAST);
  assign count    = countQ;

  always_ff @(posedge clk) begin
    if (strobes.doClear)     countQ <= '0;
    else if (strobes.doLoad) countQ <= loadVal;
    else if (strobes.doStep) countQ <= stepVal;
  end
endmodule

// File: rtl/wrapCounter.sv
module wrapCounter
  import wrapCounterPkg::*;
#(
  parameter int MOD = 10,
  localparam int W = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic         cnt,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         termCnt
);
  ctrlStrobes_t strobes;
  logic         atLast;

  wrapCounterCtrl uCtrl (
    .clr(clr), .ld(ld), .cnt(cnt), .atLast(atLast),
    .strobes(strobes), .termCnt(termCnt)
  );

  wrapCounterPath #(.MOD(MOD)) uPath (
    .clk(clk), .strobes(strobes), .loadVal(loadVal),
    .count(count), .atLast(atLast)
  );
endmodule

// File: rtl/wrapCounterChecker.sv
module wrapCounterChecker #(
  parameter int MOD = 10,
  localparam int W = (MOD > 2) ? $clog2(MOD) : 1
) (
  input logic         clk,
  input logic         clr,
  input logic         ld,
  input logic         cnt,
  input logic [W-1:0] loadVal,
  input logic [W-1:0] count,
  input logic         termCnt
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  // Count is defined only after a first clear
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  a_r1_clear: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (count == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (!armed)
    (!clr && ld) |=> (count == $past(loadVal)));

  a_r3_step: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && cnt && count < LAST) |=> (count == $past(count) + 1'b1));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && cnt && count == LAST) |=> (count == '0));

  a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && !cnt) |=> $stable(count));

  a_r6_tc_only_at_last: assert property (@(posedge clk) disable iff (!armed)
    termCnt |-> (cnt && count == LAST));

  a_r7_out_of_range_wrap: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && cnt && count > LAST) |=> (count == '0 && !$past(termCnt)));

  a_r8_tc_unmasked: assert property (@(posedge clk) disable iff (!armed)
    (cnt && count == LAST) |-> termCnt);
endmodule

bind wrapCounter wrapCounterChecker #(.MOD(MOD)) uChk (
  .clk(clk), .clr(clr), .ld(ld), .cnt(cnt),
  .loadVal(loadVal), .count(count), .termCnt(termCnt)
);

// File: tb/tb_wrapCounter.sv
module tb_wrapCounter;
  localparam int MOD = 10;
  localparam int W = $clog2(MOD);

  logic         clk = 1'b0;
  logic         clr = 1'b0, ld = 1'b0, cnt = 1'b0;
  logic [W-1:0] loadVal = '0;
  logic [W-1:0] count;
  logic         termCnt;

  int total = 0;
  int bad = 0;
  int refQ = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wrapCounter #(.MOD(MOD)) dut (
    .clk(clk), .clr(clr), .ld(ld), .cnt(cnt),
    .loadVal(loadVal), .count(count), .termCnt(termCnt)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, check flag, clock, update model, check count
  task automatic step(bit c, bit l, bit n, int d);
    string req;
    int expTc;
    clr = c; ld = l; cnt = n; loadVal = W'(d);
    #1;
    expTc = (n && refQ == MOD - 1) ? 1 : 0;
    check((c || l) ? "R8" : (refQ >= MOD ? "R7" : "R6"), int'(termCnt), expTc);
    @(posedge clk);
    if (c)      begin req = "R1"; refQ = 0; end
    else if (l) begin req = "R2"; refQ = d; end
    else if (n) begin
      req = (refQ >= MOD) ? "R7" : (refQ == MOD - 1) ? "R4" : "R3";
      refQ = (refQ >= MOD - 1) ? 0 : refQ + 1;
    end
    else req = "R5";
    @(negedge clk);
    check(req, int'(count), refQ);
  endtask

  initial begin
    @(negedge clk);
    step(1, 1, 1, 5);                        // R1 reset state with all controls
    for (int i = 0; i < 25; i++) step(0, 0, 1, 0);   // R3 R4 repeated wraps
    step(0, 1, 1, 7);                        // R2 load beats count
    step(0, 0, 0, 3);                        // R5 hold
    step(0, 0, 0, 3);
    step(0, 1, 0, MOD - 1);                  // load top value
    step(0, 0, 0, 0);                        // R6 flag low while holding
    step(1, 0, 1, 0);                        // R8 flag up during clear
    step(0, 1, 0, MOD - 1);
    step(0, 1, 1, 2);                        // R8 flag up during load
    for (int v = MOD; v < (1 << W); v++) begin
      step(0, 1, 0, v);                      // R7 out-of-range load
      step(0, 0, 0, 0);
      step(0, 0, 1, 0);                      // R7 wraps to zero
    end
    step(1, 1, 0, 9);                        // R1 clear beats load
    for (int i = 0; i < 400; i++)
      step(($urandom % 16) == 0, ($urandom % 6) == 0, $urandom % 2, $urandom % (1 << W));
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule